// File: doc/BRIEF.md
# USB IN Endpoint Transmit Controller

This block drives one bulk or interrupt IN endpoint on the device side of a USB link. Firmware loads packet bytes into a small transmit FIFO, then arms the endpoint by raising a ready flag. When the token decoder reports an IN token for this endpoint, the block does one of two things. If the endpoint is armed, it sends the stored packet as a PID strobe carrying the data toggle, a byte stream and an end strobe. Otherwise it answers with a NAK strobe. An ACK from the host completes the packet. If no ACK arrives in time, the packet is kept so it can be sent again. Packet framing, CRC and bit-level signalling belong to a neighbouring serial engine and appear here only as strobes and a byte stream.

The controller is one state machine with these states:
- `ST_IDLE`: waiting for a token.
- `ST_NAK`: one-cycle NAK answer.
- `ST_HDR`: one-cycle packet start that carries the toggle.
- `ST_DATA`: one FIFO byte per cycle.
- `ST_EOP`: one-cycle packet end.
- `ST_WAIT`: waiting for the host ACK.

The transitions are:
- `ST_IDLE` to `ST_HDR` on a token while ready is set.
- `ST_IDLE` to `ST_NAK` on a token while ready is clear.
- `ST_NAK` to `ST_IDLE` always.
- `ST_HDR` to `ST_EOP` when the FIFO is empty, which gives a zero-length packet.
- `ST_HDR` to `ST_DATA` otherwise.
- `ST_DATA` stays in `ST_DATA` until the last byte, then goes to `ST_EOP`.
- `ST_EOP` to `ST_WAIT` always.
- `ST_WAIT` to `ST_IDLE` on ACK or on timeout.
- Any state to `ST_IDLE` when the endpoint is disabled or the ready flag is cleared by firmware.

Top module: `usb_in_ep_tx`

## Requirements
- R1: While `ep_enable` is low, an IN token produces neither `hs_nak` nor `pkt_start`, and the data toggle is forced to DATA0 (`pkt_pid` = 0).
- R2: With the endpoint enabled and `tx_rdy` low, an IN token gives exactly one `hs_nak` pulse, in the cycle after the token.
- R3: With `tx_rdy` high, an IN token gives `pkt_start` in the next cycle, with `pkt_pid` equal to the toggle (0 = DATA0, 1 = DATA1). The stored bytes then follow one per cycle on `tx_valid`/`tx_data`, in write order, and one `pkt_end` cycle closes the packet.
- R4: When the endpoint is armed with an empty FIFO, `pkt_start` is followed directly by `pkt_end`, with no `tx_valid` cycle (a zero-length packet).
- R5: A `rdy_clr` pulse clears `tx_rdy`, empties the FIFO (`fifo_level` = 0) at the next edge, and abandons any transfer in progress. The next token is answered with NAK. `rdy_clr` wins over a simultaneous `rdy_set`.
- R6: An `hs_ack` pulse received after `pkt_end` and before the timeout does four things at one edge: it sets `tx_cmpl`, clears `tx_rdy`, empties the FIFO and flips the toggle. `ep_irq` equals `tx_cmpl` AND `irq_en`.
- R7: `cmpl_clr` clears `tx_cmpl`. FIFO writes are ignored while `tx_cmpl` or `tx_rdy` is set.
- R8: If no ACK arrives within `ACK_TIMEOUT` cycles of `pkt_end`, the block returns to idle with `tx_rdy`, the FIFO contents and the toggle unchanged. The next token resends identical bytes with the same PID. An `hs_ack` outside the wait window has no effect.
- R9: Writes made while the FIFO holds `DEPTH` bytes are dropped and set the sticky `fifo_ovf` flag.
- R10: The toggle starts at DATA0 after reset or enable and changes only on an accepted ACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ep_enable | input | 1 | Endpoint enabled and configured |
| irq_en | input | 1 | Completion interrupt enable |
| wr_valid | input | 1 | Firmware FIFO write strobe |
| wr_data | input | 8 | Firmware FIFO write byte |
| rdy_set | input | 1 | Arm the endpoint |
| rdy_clr | input | 1 | Cancel the packet and flush the FIFO |
| cmpl_clr | input | 1 | Clear the completion flag |
| in_token | input | 1 | IN token for this endpoint |
| hs_ack | input | 1 | Host ACK handshake received |
| hs_nak | output | 1 | Send a NAK handshake |
| pkt_start | output | 1 | Data packet start |
| pkt_pid | output | 1 | Data toggle for the packet (0 = DATA0) |
| tx_valid | output | 1 | Payload byte valid |
| tx_data | output | 8 | Payload byte |
| pkt_end | output | 1 | Data packet end |
| tx_rdy | output | 1 | Ready flag |
| tx_cmpl | output | 1 | Completion flag |
| ep_irq | output | 1 | Endpoint interrupt |
| fifo_level | output | $clog2(DEPTH+1) | Bytes held in the FIFO |
| fifo_ovf | output | 1 | Sticky overflow flag |

## Verification
The bench targets the following corner cases:
- Retry after a missing ACK. A design that fails to rewind the read pointer sends stale or no bytes on the second attempt, and one that flips the toggle early sends the wrong PID.
- A zero-length packet. A design that gets this wrong emits a spurious byte or never ends the packet.
- Cancellation. A design that gets this wrong leaves bytes in the FIFO or keeps answering with data.
- Overflow. A design that gets this wrong wraps the write pointer and corrupts the first byte.
- Stray ACKs, tokens to a disabled endpoint, and writes during completion. A design that gets these wrong shows unexpected strobes or level changes.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NAK,
        ST_HDR,
        ST_DATA,
        ST_EOP,
        ST_WAIT
    } ep_state_t;
endpackage

// File: rtl/ep_tx_fifo.sv
module ep_tx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [DW-1:0]                wr_data,
    input  logic                         flush,
    input  logic                         rewind,
    input  logic                         advance,
    output logic [DW-1:0]                rd_data,
    output logic                         rd_last,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         overflow
);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH+1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] rd_ptr;
    logic          full;

    assign full    = (level == LVL_W'(DEPTH));
    assign rd_data = mem[rd_ptr];
    assign rd_last = ((LVL_W'(rd_ptr) + LVL_W'(1)) == level);

    always_ff @(posedge clk) begin
        if (wr_en && !full && !flush)
            mem[level[AW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level    <= '0;
            rd_ptr   <= '0;
            overflow <= 1'b0;
        end else begin
            if (wr_en && full)
                overflow <= 1'b1;
            if (flush) begin
                level  <= '0;
                rd_ptr <= '0;
            end else begin
                if (wr_en && !full)
                    level <= level + LVL_W'(1);
                if (rewind)
                    rd_ptr <= '0;
                else if (advance)
                    rd_ptr <= rd_ptr + AW'(1);
            end
        end
    end

    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !flush) |=> (level == LVL_W'(DEPTH) && overflow)); // R9

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH)); // R9
endmodule

// File: rtl/ep_ack_timer.sv
module ep_ack_timer #(
    parameter int TIMEOUT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

    logic [CW-1:0] cnt;

    assign expired = run && (cnt == CW'(TIMEOUT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (run && !expired)
            cnt <= cnt + CW'(1);
    end

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (32'(cnt) < TIMEOUT)); // R8
endmodule

// File: rtl/ep_tx_fsm.sv
module ep_tx_fsm
    import usb_in_ep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ep_enable,
    input  logic rdy_set,
    input  logic rdy_clr,
    input  logic cmpl_clr,
    input  logic in_token,
    input  logic hs_ack,
    input  logic fifo_empty,
    input  logic rd_last,
    input  logic tmo,
    output logic rdy_q,
    output logic cmpl_q,
    output logic tog_q,
    output logic fifo_rewind,
    output logic fifo_advance,
    output logic fifo_flush,
    output logic timer_clear,
    output logic timer_run,
    output logic hs_nak,
    output logic pkt_start,
    output logic pkt_pid,
    output logic tx_valid,
    output logic pkt_end
);
    ep_state_t st_q, st_d;
    logic      ack_hit;

    assign ack_hit = (st_q == ST_WAIT) && hs_ack && ep_enable && !rdy_clr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (!ep_enable || rdy_clr) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: if (in_token) st_d = rdy_q ? ST_HDR : ST_NAK;
                ST_NAK:  st_d = ST_IDLE;
                ST_HDR:  st_d = fifo_empty ? ST_EOP : ST_DATA;
                ST_DATA: if (rd_last) st_d = ST_EOP;
                ST_EOP:  st_d = ST_WAIT;
                ST_WAIT: if (hs_ack || tmo) st_d = ST_IDLE;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        hs_nak       = 1'b0;
        pkt_start    = 1'b0;
        tx_valid     = 1'b0;
        pkt_end      = 1'b0;
        fifo_rewind  = 1'b0;
        fifo_advance = 1'b0;
        timer_clear  = 1'b0;
        timer_run    = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_NAK:  hs_nak = 1'b1;
            ST_HDR: begin
                pkt_start   = 1'b1;
                fifo_rewind = 1'b1;
            end
            ST_DATA: begin
                tx_valid     = 1'b1;
                fifo_advance = 1'b1;
            end
            ST_EOP: begin
                pkt_end     = 1'b1;
                timer_clear = 1'b1;
            end
            ST_WAIT: timer_run = 1'b1;
            default: ;
        endcase
        pkt_pid    = tog_q;
        fifo_flush = rdy_clr || ack_hit;
    end

    // firmware handshake flags and data toggle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_q  <= 1'b0;
            cmpl_q <= 1'b0;
            tog_q  <= 1'b0;
        end else begin
            if (rdy_clr || ack_hit)
                rdy_q <= 1'b0;
            else if (rdy_set)
                rdy_q <= 1'b1;

            if (ack_hit)
                cmpl_q <= 1'b1;
            else if (cmpl_clr)
                cmpl_q <= 1'b0;

            if (!ep_enable)
                tog_q <= 1'b0;
            else if (ack_hit)
                tog_q <= ~tog_q;
        end
    end

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !ep_enable |=> (!hs_nak && !pkt_start && !tog_q)); // R1

    AST_NAK_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && in_token && ep_enable && !rdy_clr && !rdy_q) |=> hs_nak); // R2

    AST_ACK_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT && hs_ack && ep_enable && !rdy_clr) |=> (cmpl_q && !rdy_q && st_q == ST_IDLE)); // R6

    AST_TOGGLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_enable && !(st_q == ST_WAIT && hs_ack && !rdy_clr)) |=> $stable(tog_q)); // R10

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hs_nak, pkt_start, tx_valid, pkt_end})); // R3
endmodule

// File: rtl/usb_in_ep_tx.sv
module usb_in_ep_tx #(
    parameter int DW          = 8,
    parameter int DEPTH       = 8,
    parameter int ACK_TIMEOUT = 32,
    localparam int LVL_W      = $clog2(DEPTH+1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ep_enable,
    input  logic             irq_en,
    input  logic             wr_valid,
    input  logic [DW-1:0]    wr_data,
    input  logic             rdy_set,
    input  logic             rdy_clr,
    input  logic             cmpl_clr,
    input  logic             in_token,
    input  logic             hs_ack,
    output logic             hs_nak,
    output logic             pkt_start,
    output logic             pkt_pid,
    output logic             tx_valid,
    output logic [DW-1:0]    tx_data,
    output logic             pkt_end,
    output logic             tx_rdy,
    output logic             tx_cmpl,
    output logic             ep_irq,
    output logic [LVL_W-1:0] fifo_level,
    output logic             fifo_ovf
);
    logic fifo_wr, fifo_rewind, fifo_advance, fifo_flush, rd_last;
    logic timer_clear, timer_run, tmo;
    logic tog;

    assign fifo_wr = wr_valid && !tx_rdy && !tx_cmpl;
    assign ep_irq  = tx_cmpl && irq_en;

    ep_tx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (fifo_wr),
        .wr_data  (wr_data),
        .flush    (fifo_flush),
        .rewind   (fifo_rewind),
        .advance  (fifo_advance),
        .rd_data  (tx_data),
        .rd_last  (rd_last),
        .level    (fifo_level),
        .overflow (fifo_ovf)
    );

    ep_ack_timer #(.TIMEOUT(ACK_TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (timer_clear),
        .run     (timer_run),
        .expired (tmo)
    );

    ep_tx_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ep_enable    (ep_enable),
        .rdy_set      (rdy_set),
        .rdy_clr      (rdy_clr),
        .cmpl_clr     (cmpl_clr),
        .in_token     (in_token),
        .hs_ack       (hs_ack),
        .fifo_empty   (fifo_level == '0),
        .rd_last      (rd_last),
        .tmo          (tmo),
        .rdy_q        (tx_rdy),
        .cmpl_q       (tx_cmpl),
        .tog_q        (tog),
        .fifo_rewind  (fifo_rewind),
        .fifo_advance (fifo_advance),
        .fifo_flush   (fifo_flush),
        .timer_clear  (timer_clear),
        .timer_run    (timer_run),
        .hs_nak       (hs_nak),
        .pkt_start    (pkt_start),
        .pkt_pid      (pkt_pid),
        .tx_valid     (tx_valid),
        .pkt_end      (pkt_end)
    );

    AST_CANCEL_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_clr |=> (fifo_level == '0 && !tx_rdy)); // R5

    AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && (tx_rdy || tx_cmpl) && !rdy_clr && !fifo_flush) |=> $stable(fifo_level)); // R7
endmodule

// File: tb/usb_in_ep_tx_test.sv
`timescale 1ns/1ps
module usb_in_ep_tx_test;
    localparam int DW = 8, DEPTH = 8, TMO = 32;
    localparam int LVL_W = $clog2(DEPTH+1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic ep_enable = 0, irq_en = 0, wr_valid = 0, rdy_set = 0, rdy_clr = 0;
    logic cmpl_clr = 0, in_token = 0, hs_ack = 0;
    logic [DW-1:0] wr_data = '0;
    logic hs_nak, pkt_start, pkt_pid, tx_valid, pkt_end, tx_rdy, tx_cmpl, ep_irq, fifo_ovf;
    logic [DW-1:0] tx_data;
    logic [LVL_W-1:0] fifo_level;

    always #2.5 clk = ~clk;

    usb_in_ep_tx #(.DW(DW), .DEPTH(DEPTH), .ACK_TIMEOUT(TMO)) uut (.*);

    typedef struct { int kind; int val; string req; } ev_t; // kind 0 NAK,1 PID,2 DATA,3 END
    ev_t exp_q[$];
    int checks = 0, errors = 0;
    bit mon_on = 0;

    // bench model
    byte model_q[$];
    bit m_rdy = 0, m_cmpl = 0, m_tog = 0, m_en = 0;

    task automatic check(string req, int act, int expv, string what);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // monitor: scoreboard compare
    always @(negedge clk) begin
        if (mon_on) begin
            int k, v;
            k = -1; v = 0;
            if (hs_nak) k = 0;
            else if (pkt_start) begin k = 1; v = int'(pkt_pid); end
            else if (tx_valid) begin k = 2; v = int'(tx_data); end
            else if (pkt_end) k = 3;
            if (k >= 0) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R1 unexpected event: actual kind %0d expected none", k);
                end else begin
                    ev_t e;
                    e = exp_q.pop_front();
                    check(e.req, k, e.kind, "event kind");
                    check(e.req, v, e.val, "event value");
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic cyc(int n); repeat (n) @(negedge clk); endtask

    task automatic wr(byte b);
        wr_valid = 1; wr_data = b;
        cyc(1);
        wr_valid = 0;
        if (!m_rdy && !m_cmpl && model_q.size() < DEPTH) model_q.push_back(b);
    endtask

    task automatic arm();
        rdy_set = 1; cyc(1); rdy_set = 0; m_rdy = 1;
    endtask

    task automatic token(string req);
        if (m_en) begin
            if (m_rdy) begin
                exp_q.push_back('{1, int'(m_tog), req});
                foreach (model_q[i]) exp_q.push_back('{2, int'(model_q[i]) & 8'hff, req});
                exp_q.push_back('{3, 0, req});
            end else exp_q.push_back('{0, 0, req});
        end
        in_token = 1; cyc(1); in_token = 0;
        cyc(DEPTH + 4);
    endtask

    task automatic ack();
        hs_ack = 1; cyc(1); hs_ack = 0;
        m_cmpl = 1; m_rdy = 0; model_q.delete(); m_tog = ~m_tog;
    endtask

    task automatic clr_cmpl();
        cmpl_clr = 1; cyc(1); cmpl_clr = 0; m_cmpl = 0;
    endtask

    task automatic drained(string req);
        check(req, exp_q.size(), 0, "pending expected events");
    endtask

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        // reset state
        check("R10", int'(tx_rdy), 0, "reset tx_rdy");
        check("R10", int'(tx_cmpl), 0, "reset tx_cmpl");
        check("R10", int'(fifo_level), 0, "reset level");
        check("R9", int'(fifo_ovf), 0, "reset ovf");
        check("R10", int'(pkt_pid), 0, "reset toggle");
        mon_on = 1;

        // R1: disabled endpoint, armed, stays silent
        wr(8'h11); arm();
        token("R1"); drained("R1");
        // cancel that packet R5
        rdy_clr = 1; rdy_set = 1; cyc(1); rdy_clr = 0; rdy_set = 0;
        m_rdy = 0; model_q.delete();
        check("R5", int'(tx_rdy), 0, "rdy after clr beats set");
        check("R5", int'(fifo_level), 0, "level after cancel");

        ep_enable = 1; m_en = 1; irq_en = 1;
        // R2: NAK when unarmed
        token("R2"); drained("R2");

        // R3: three-byte packet, DATA0
        wr(8'hA1); wr(8'hB2); wr(8'hC3);
        check("R3", int'(fifo_level), 3, "level after writes");
        arm();
        wr(8'h55);
        check("R7", int'(fifo_level), 3, "write while armed ignored");
        token("R3"); drained("R3");
        ack();
        check("R6", int'(tx_cmpl), 1, "cmpl after ack");
        check("R6", int'(tx_rdy), 0, "rdy after ack");
        check("R6", int'(ep_irq), 1, "irq after ack");
        check("R6", int'(fifo_level), 0, "level after ack");
        check("R10", int'(pkt_pid), 1, "toggle after ack");
        wr(8'h66);
        check("R7", int'(fifo_level), 0, "write while complete ignored");
        clr_cmpl();
        check("R7", int'(tx_cmpl), 0, "cmpl cleared");
        check("R6", int'(ep_irq), 0, "irq after clear");

        // R8: retry after missing ACK
        wr(8'h0F); wr(8'hF0); arm();
        token("R8"); drained("R8");
        cyc(TMO + 4);
        check("R8", int'(tx_rdy), 1, "rdy kept after timeout");
        check("R8", int'(tx_cmpl), 0, "no cmpl after timeout");
        check("R8", int'(fifo_level), 2, "bytes kept after timeout");
        check("R10", int'(pkt_pid), 1, "toggle kept after timeout");
        hs_ack = 1; cyc(1); hs_ack = 0;
        check("R8", int'(tx_cmpl), 0, "stray ack ignored");
        token("R8"); drained("R8");
        ack(); clr_cmpl();
        check("R10", int'(pkt_pid), 0, "toggle back to DATA0");

        // R4: zero-length packet
        arm();
        token("R4"); drained("R4");
        irq_en = 0;
        ack();
        check("R4", int'(tx_cmpl), 1, "zlp completes");
        check("R6", int'(ep_irq), 0, "irq masked");
        clr_cmpl();

        // R5: cancel then NAK
        wr(8'h21); wr(8'h22); arm();
        rdy_clr = 1; cyc(1); rdy_clr = 0; m_rdy = 0; model_q.delete();
        check("R5", int'(fifo_level), 0, "cancel flush");
        token("R5"); drained("R5");

        // R9: overflow
        for (int i = 0; i < DEPTH + 2; i++) wr(byte'(8'h30 + i));
        check("R9", int'(fifo_level), DEPTH, "level capped");
        check("R9", int'(fifo_ovf), 1, "overflow sticky");
        arm();
        token("R9"); drained("R9");
        ack(); clr_cmpl();
        check("R9", int'(fifo_ovf), 1, "overflow still set");

        // R1: disable resets toggle
        check("R10", int'(pkt_pid), 0, "toggle before disable");
        arm(); token("R1"); ack(); clr_cmpl();
        check("R10", int'(pkt_pid), 1, "toggle DATA1");
        ep_enable = 0; m_en = 0; cyc(1);
        check("R1", int'(pkt_pid), 0, "toggle reset on disable");
        drained("R1");

        cyc(4);
        finish_run();
    end
endmodule